// File: doc/BRIEF.md
# Every-Nth Packet Dropper

This block sits in a router's packet pipeline between two stages that exchange 64-bit data words, each tagged with an 8-bit control byte and moved by a write strobe with a ready signal. It counts packet starts. When dropping is switched on, every Nth whole packet is thrown away and every other packet is passed through word for word. Forwarded words reach the output in the same cycle, with no storage in between.

The period N and an on/off switch are written through a small register port. The current packet count and the number of packets discarded so far are driven out as plain read-back outputs. A one-cycle clear pulse zeroes the packet count. Words of a discarded packet are still taken from upstream, so the upstream stage is never stalled by a drop.

Top module: `pkt_nth_filter`

## Requirements
- R1: A word is accepted when in_wr and in_rdy are both high. A packet begins with an accepted word whose control byte is 0xFF while no packet is open. The words after it that carry a nonzero control byte are further header words. Data words carry control 0x00. The packet ends with the first accepted word that carries a nonzero control byte after at least one data word. Words accepted while no packet is open and whose control byte is not 0xFF pass through and are not counted.
- R2: The packet count (CNT_W bits, 16 by default) goes up by one on each packet start that is not dropped, and wraps from its maximum to 0.
- R3: A high clr_pulse sets the packet count to 0 at the next edge. It takes priority over an increment in the same cycle.
- R4: With dropping enabled and N at least 1, a packet is dropped when its start finds count+1 >= N. The count then returns to 0, and none of that packet's words, through its last word, appear at the output.
- R5: N = 0 never drops. N = 1 drops every packet.
- R6: With dropping disabled, every packet passes and the count keeps counting.
- R7: A forwarded word appears on out_data/out_ctrl with out_wr high in the same cycle it is accepted, unchanged.
- R8: While a dropped packet is open, in_rdy is 1 whatever out_rdy is, and out_wr stays 0.
- R9: Outside a dropped packet, in_rdy equals out_rdy.
- R10: cfg_sel 0 writes the period N from cfg_wdata, and cfg_sel 1 writes the enable from cfg_wdata bit 0. The drop decision uses the values held before the packet's first word is accepted. A change written later never alters a packet already started.
- R11: The drop count (DROP_W bits, 32 by default) goes up by one for each dropped packet and holds at its all-ones maximum.
- R12: After reset, both counts are 0, N is 0, dropping is disabled, and no packet is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | DATA_W | Upstream data word |
| in_ctrl | input | CTRL_W | Upstream control byte |
| in_wr | input | 1 | Upstream write strobe |
| in_rdy | output | 1 | Ready toward upstream |
| out_data | output | DATA_W | Downstream data word |
| out_ctrl | output | CTRL_W | Downstream control byte |
| out_wr | output | 1 | Downstream write strobe |
| out_rdy | input | 1 | Ready from downstream |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = period, 1 = enable |
| cfg_wdata | input | CNT_W | Configuration write value |
| clr_pulse | input | 1 | One-cycle clear of the packet count |
| pkt_count | output | CNT_W | Packet count read-back |
| drop_count | output | DROP_W | Dropped-packet count read-back |

## Verification
The bench runs reduced counter widths so that two edge cases come up within a short run: the packet count wrapping and the drop count saturating. A design that wraps the drop count would suddenly report few drops, and a wrong wrap would miss or add drops. It applies random downstream backpressure inside dropped packets, where a design that kept ready tied to downstream would stall the upstream stage. It rewrites N and the enable in the middle of a packet, where a design that sampled the registers late would cut off a packet partway and send a truncated fragment on. It also covers N = 0, N = 1, and a clear pulse landing on a start word, which catch a modulus off by one and the wrong clear priority.

// File: rtl/pnf_pkg.sv
package pnf_pkg;
  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_HDR  = 2'd1,
    FR_BODY = 2'd2
  } frame_t;

  localparam logic CFG_PERIOD = 1'b0;
  localparam logic CFG_ENABLE = 1'b1;
endpackage

// File: rtl/pnf_rst_sync.sv
module pnf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pnf_framer.sv
module pnf_framer import pnf_pkg::*; #(
  parameter int CTRL_W = 8,
  parameter logic [CTRL_W-1:0] START_CODE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              hit,
  output logic              start,
  output logic              drop_now,
  output logic              dropping
);
  frame_t st_q, st_d;
  logic   drop_d;
  logic   last_word;

  assign start     = acc && (st_q == FR_IDLE) && (ctrl == START_CODE);
  assign last_word = acc && (st_q == FR_BODY) && (ctrl != '0);
  assign drop_now  = start ? hit : dropping;

  always_comb begin
    st_d = st_q;
    case (st_q)
      FR_IDLE: if (start) st_d = FR_HDR;
      FR_HDR:  if (acc && ctrl == '0) st_d = FR_BODY;
      FR_BODY: if (last_word) st_d = FR_IDLE;
      default: st_d = FR_IDLE;
    endcase
  end

  always_comb begin
    drop_d = dropping;
    if (start)          drop_d = hit;
    else if (last_word) drop_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= FR_IDLE;
      dropping <= 1'b0;
    end else begin
      st_q     <= st_d;
      dropping <= drop_d;
    end
  end
endmodule

// File: rtl/pnf_period_cnt.sv
module pnf_period_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  input  logic             enable,
  input  logic [CNT_W-1:0] period,
  output logic             hit,
  output logic [CNT_W-1:0] count
);
  localparam int EXT_W = CNT_W + 1;

  logic [EXT_W-1:0] count_plus;
  logic [CNT_W-1:0] count_d;

  assign count_plus = {1'b0, count} + EXT_W'(1);
  assign hit = enable && (period != '0) && (count_plus >= {1'b0, period});

  always_comb begin
    count_d = count;
    if (clr)      count_d = '0;
    else if (inc) count_d = hit ? '0 : count_plus[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end
endmodule

// File: rtl/pnf_sat_cnt.sv
module pnf_sat_cnt #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] TOP = '1;

  logic [WIDTH-1:0] count_d;
  logic             step_en;

  assign step_en = inc && (count != TOP);

  always_comb begin
    count_d = count;
    if (step_en) count_d = count + WIDTH'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end
endmodule

// File: rtl/pkt_nth_filter.sv
module pkt_nth_filter import pnf_pkg::*; #(
  parameter int DATA_W = 64,
  parameter int CTRL_W = 8,
  parameter int CNT_W  = 16,
  parameter int DROP_W = 32,
  parameter logic [CTRL_W-1:0] START_CODE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CTRL_W-1:0] in_ctrl,
  input  logic              in_wr,
  output logic              in_rdy,
  output logic [DATA_W-1:0] out_data,
  output logic [CTRL_W-1:0] out_ctrl,
  output logic              out_wr,
  input  logic              out_rdy,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [CNT_W-1:0]  cfg_wdata,
  input  logic              clr_pulse,
  output logic [CNT_W-1:0]  pkt_count,
  output logic [DROP_W-1:0] drop_count
);
  logic             srst_n;
  logic [CNT_W-1:0] period_q, period_d;
  logic             enable_q, enable_d;
  logic             acc, start, hit, drop_now, dropping;

  pnf_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  always_comb begin
    period_d = period_q;
    enable_d = enable_q;
    if (cfg_wr) begin
      if (cfg_sel == CFG_PERIOD) period_d = cfg_wdata;
      else                       enable_d = cfg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      period_q <= '0;
      enable_q <= 1'b0;
    end else begin
      period_q <= period_d;
      enable_q <= enable_d;
    end
  end

  assign in_rdy = dropping | out_rdy;
  assign acc    = in_wr & in_rdy;

  pnf_framer #(.CTRL_W(CTRL_W), .START_CODE(START_CODE)) u_frame (
    .clk(clk), .rst_n(srst_n), .acc(acc), .ctrl(in_ctrl), .hit(hit),
    .start(start), .drop_now(drop_now), .dropping(dropping)
  );

  pnf_period_cnt #(.CNT_W(CNT_W)) u_period (
    .clk(clk), .rst_n(srst_n), .inc(start), .clr(clr_pulse),
    .enable(enable_q), .period(period_q), .hit(hit), .count(pkt_count)
  );

  pnf_sat_cnt #(.WIDTH(DROP_W)) u_drops (
    .clk(clk), .rst_n(srst_n), .inc(start & hit), .count(drop_count)
  );

  assign out_wr   = acc & ~drop_now;
  assign out_data = in_data;
  assign out_ctrl = in_ctrl;
endmodule

// File: rtl/pnf_checker.sv
module pnf_checker #(
  parameter int CNT_W  = 16,
  parameter int DROP_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_wr,
  input logic              in_rdy,
  input logic              out_wr,
  input logic              clr_pulse,
  input logic [CNT_W-1:0]  pkt_count,
  input logic [DROP_W-1:0] drop_count,
  input logic              dropping
);
  localparam logic [DROP_W-1:0] DTOP = '1;
  localparam logic [CNT_W-1:0]  CONE = CNT_W'(1);

  AST_OUT_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |-> (in_wr && in_rdy)); // R7

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (pkt_count == '0)); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pkt_count == $past(pkt_count) || pkt_count == ($past(pkt_count) + CONE)
              || pkt_count == '0)); // R2

  AST_DROP_RESETS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drop_count == $past(drop_count) || pkt_count == '0)); // R4

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    dropping |-> (in_rdy && !out_wr)); // R8

  AST_DROPS_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drop_count >= $past(drop_count))); // R11

  AST_DROPS_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == DTOP) |=> (drop_count == DTOP)); // R11
endmodule

bind pkt_nth_filter pnf_checker #(.CNT_W(CNT_W), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_wr(in_wr), .in_rdy(in_rdy), .out_wr(out_wr),
  .clr_pulse(clr_pulse), .pkt_count(pkt_count), .drop_count(drop_count),
  .dropping(dropping)
);

// File: tb/sim_pkt_nth_filter.sv
module sim_pkt_nth_filter;
  localparam int CW = 4;
  localparam int DW = 4;
  localparam int CMAX = (1 << CW) - 1;
  localparam int DMAX = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [63:0]   in_data;
  logic [7:0]    in_ctrl;
  logic          in_wr;
  logic          in_rdy;
  logic [63:0]   out_data;
  logic [7:0]    out_ctrl;
  logic          out_wr;
  logic          out_rdy;
  logic          cfg_wr;
  logic          cfg_sel;
  logic [CW-1:0] cfg_wdata;
  logic          clr_pulse;
  logic [CW-1:0] pkt_count;
  logic [DW-1:0] drop_count;

  int    checks = 0;
  int    fails = 0;
  string cur_req = "R12";
  bit    bp_en = 0;
  bit    last_acc;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference state
  int m_st = 0;     // 0 idle, 1 header, 2 body
  bit m_drop = 0;
  int m_cnt = 0;
  int m_drops = 0;
  int m_n = 0;
  bit m_en = 0;

  always #2 clk = ~clk;

  pkt_nth_filter #(.CNT_W(CW), .DROP_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_ctrl(in_ctrl),
    .in_wr(in_wr), .in_rdy(in_rdy), .out_data(out_data), .out_ctrl(out_ctrl),
    .out_wr(out_wr), .out_rdy(out_rdy), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .clr_pulse(clr_pulse), .pkt_count(pkt_count),
    .drop_count(drop_count)
  );

  task automatic chk(string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %0h expected %0h", cur_req, what, got, exp);
    end
  endtask

  task automatic tick();
    bit e_rdy, acc, start, hit, dn, e_wr, endw;
    #1;
    e_rdy = m_drop || out_rdy;
    acc   = in_wr && e_rdy;
    start = acc && (m_st == 0) && (in_ctrl == 8'hFF);
    hit   = m_en && (m_n != 0) && (m_cnt + 1 >= m_n);
    dn    = start ? hit : m_drop;
    e_wr  = acc && !dn;
    endw  = acc && (m_st == 2) && (in_ctrl != 8'h00);
    chk("in_rdy", in_rdy, e_rdy);
    chk("out_wr", out_wr, e_wr);
    if (e_wr) begin
      chk("out_data", out_data, in_data);
      chk("out_ctrl", out_ctrl, in_ctrl);
    end
    chk("pkt_count", pkt_count, m_cnt);
    chk("drop_count", drop_count, m_drops);
    last_acc = acc;
    @(posedge clk);
    if (start)                                  m_st = 1;
    else if (m_st == 1 && acc && in_ctrl == 0)  m_st = 2;
    else if (endw)                              m_st = 0;
    if (start)     m_drop = hit;
    else if (endw) m_drop = 0;
    if (clr_pulse)  m_cnt = 0;
    else if (start) m_cnt = hit ? 0 : (m_cnt + 1) % (CMAX + 1);
    if (start && hit && m_drops < DMAX) m_drops++;
    if (cfg_wr) begin
      if (cfg_sel == 1'b0) m_n = int'(cfg_wdata);
      else                 m_en = cfg_wdata[0];
    end
    @(negedge clk);
    cfg_wr    = 1'b0;
    clr_pulse = 1'b0;
    lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_rdy   = bp_en ? lfsr[0] : 1'b1;
  endtask

  task automatic send_word(logic [63:0] d, logic [7:0] c);
    in_data = d;
    in_ctrl = c;
    in_wr   = 1'b1;
    do tick(); while (!last_acc);
    in_wr = 1'b0;
  endtask

  task automatic send_pkt(int id, int hdrs, int datas);
    send_word({32'hA000_0000 | id, 32'h0}, 8'hFF);
    for (int i = 0; i < hdrs; i++) send_word({id, i, 16'h1111}, 8'h02);
    for (int i = 0; i < datas; i++) send_word({id, i, 16'hD0D0}, 8'h00);
    send_word({id, 32'hE0E0_E0E0}, 8'h40);
    tick();
  endtask

  task automatic cfg(bit sel, int val);
    cfg_wr    = 1'b1;
    cfg_sel   = sel;
    cfg_wdata = CW'(val);
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_data = '0; in_ctrl = '0; in_wr = 1'b0; out_rdy = 1'b1;
    cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0; clr_pulse = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    cur_req = "R12";                      // reset state
    tick(); tick();

    cur_req = "R6";                       // disabled: all pass, counting
    for (int p = 0; p < 5; p++) send_pkt(p, 0, 2);
    chk("R6 count after 5", pkt_count, 5);

    cur_req = "R2";                       // wrap of packet count
    for (int p = 0; p < 13; p++) send_pkt(p + 10, 1, 1);
    chk("R2 wrapped count", pkt_count, 2);

    cur_req = "R1";                       // stray words and multi-word headers
    send_word(64'h5555, 8'h00);
    send_word(64'h6666, 8'h03);
    tick();
    send_pkt(40, 3, 4);
    chk("R1 count", pkt_count, 3);

    cur_req = "R3";                       // clear, alone and on a start word
    clr_pulse = 1'b1; tick();
    chk("R3 cleared", pkt_count, 0);
    send_pkt(41, 0, 1);
    clr_pulse = 1'b1;
    send_pkt(42, 0, 1);

    cur_req = "R4";                       // every third with backpressure
    cfg(1'b0, 3); cfg(1'b1, 1);
    clr_pulse = 1'b1; tick();
    bp_en = 1;
    for (int p = 0; p < 9; p++) send_pkt(50 + p, 1, 3);
    chk("R4 drops", drop_count, 3);
    cur_req = "R8";
    for (int p = 0; p < 6; p++) send_pkt(60 + p, 0, 5);
    cur_req = "R9";
    for (int p = 0; p < 2; p++) send_pkt(70 + p, 0, 2);
    cur_req = "R7";
    for (int p = 0; p < 3; p++) send_pkt(75 + p, 2, 2);
    bp_en = 0;

    cur_req = "R5";                       // N = 0 and N = 1
    cfg(1'b0, 0);
    for (int p = 0; p < 4; p++) send_pkt(80 + p, 0, 1);
    cfg(1'b0, 1);
    for (int p = 0; p < 2; p++) send_pkt(85 + p, 0, 1);
    chk("R5 N=1 count", pkt_count, 0);

    cur_req = "R10";                      // mid-packet changes
    cfg(1'b0, 2);
    clr_pulse = 1'b1; tick();
    send_pkt(90, 0, 1);                   // count 1
    send_word(64'h9100, 8'hFF);           // dropped start
    cfg(1'b1, 0);                         // disable mid-packet
    send_word(64'h9101, 8'h00);
    send_word(64'h9102, 8'h40);
    tick();
    cfg(1'b1, 1);
    send_word(64'h9200, 8'hFF);           // passes (count 0 -> 1)
    cfg(1'b0, 1);                         // N=1 mid-packet
    send_word(64'h9201, 8'h00);
    send_word(64'h9202, 8'h40);
    tick();

    cur_req = "R11";                      // saturation
    for (int p = 0; p < 18; p++) send_pkt(100 + p, 0, 1);
    chk("R11 saturated", drop_count, DMAX);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule